// File: doc/BRIEF.md
# TDM Frame-Sync Pulse Generator

This block produces the per-channel frame-sync strobes that tell PCM codecs on a time-division bus when their eight-bit slot is on the wire. It runs from the bit clock: every rising edge of `clk` in this design stands for the bit-clock edge that launches frame-sync transitions. Frames are aligned by a transmit frame-start input and a receive frame-start input. It has eight strobe outputs, four for transmit and four for receive. Each output is high for the whole of the one slot whose number matches the slot number assigned to it.

Each direction has a slot timer built as a small state machine with three states. `TM_IDLE` means no frame has begun since reset. `TM_RUN` means slots are being counted. `TM_HALT` means the count has run past slot 31 with no new frame start. The transitions are:
- start: `TM_IDLE` to `TM_RUN` on a frame-start edge.
- restart: `TM_RUN` to `TM_RUN` on a frame-start edge.
- overrun: `TM_RUN` to `TM_HALT` when the count would reach 32.
- resume: `TM_HALT` to `TM_RUN` on a frame-start edge.

In separate-direction mode (`mode2` low), the receive lanes follow their own timer. In shared mode (`mode2` high), all eight lanes follow the transmit timer, and the receive frame-start input is ignored. Slot assignments come from an external loader through a one-cycle write port. A write is held as pending. It is applied only at the next slot boundary, so an output never changes partway through a slot.

An active-low bus-enable is given as an output-enable flag plus the level seen on a pulled-up wired-AND line. It tells a line driver when this block's codecs own the transmit bus.

Top module: `tdm_fsync_gen`

## Requirements
- R1: After reset all eight strobes are low, `bus_oe` is 0 and `bus_lvl_n` is 1. No strobe rises until a lane has been given a valid assignment and a frame has started.
- R2: A clock edge where a frame-start input is sampled high after being sampled low (or at the first edge after reset) starts slot 0 at that edge. A lane assigned slot 0 is high from that edge.
- R3: The slot count advances once every 8 clocks. A lane assigned slot N is high for exactly 8 consecutive clocks, starting 8*N clocks after the frame-start edge.
- R4: With `mode2`=0, receive lanes are timed from `rx_sync` alone. Transmit and receive frames may have any phase offset.
- R5: With `mode2`=1, receive lanes are timed from the transmit timer, and `rx_sync` has no effect on any output.
- R6: After slot 31 the count holds at 32 and no lane pulses until the next frame start. A slot number that the frame never reaches never pulses.
- R7: A write takes effect at the first slot boundary after the clock edge that samples it. Outputs change only at slot boundaries.
- R8: A write with `cfg_off`=1, or with `cfg_slot[5]`=1, leaves that lane permanently low until it is rewritten.
- R9: `bus_oe` is 1 exactly while any transmit strobe is high (mode 1), or while any strobe is high (mode 2). `bus_lvl_n` is its complement.
- R10: `cfg_lane` values 0..3 select transmit lanes 0..3. Values 4..7 select receive lanes 0..3. `cfg_slot[4:0]` is the slot number.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock (launch edge) |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode2 | input | 1 | 0: separate transmit/receive timing; 1: all lanes on transmit timing |
| tx_sync | input | 1 | Transmit frame-start |
| rx_sync | input | 1 | Receive frame-start (ignored when mode2=1) |
| cfg_we | input | 1 | Assignment write strobe |
| cfg_lane | input | 3 | Lane selected by the write |
| cfg_off | input | 1 | Write disables the lane |
| cfg_slot | input | 6 | Slot number; bit 5 set means inactive |
| fs_tx | output | 4 | Transmit frame-sync strobes |
| fs_rx | output | 4 | Receive frame-sync strobes |
| bus_oe | output | 1 | Pull-down enable of the bus-enable line |
| bus_lvl_n | output | 1 | Resolved level of the bus-enable line |

## Verification
The hardest state to reach is `TM_HALT`. Getting there needs a frame that runs past slot 31 with no new frame start. That never happens under a regular frame period. The stimulus therefore first runs short ten-slot frames, where a slot-31 lane must stay silent. It then stops the frame-start input completely, so the timer overruns and must stay quiet. Assignment writes are also placed at arbitrary cycles inside slots, so that the boundary-only update is exercised against the reference model on every clock.

// File: rtl/tsg_pkg.sv
package tsg_pkg;
    localparam int TSG_LANES      = 4;
    localparam int TSG_SLOT_W     = 6;
    localparam int TSG_BITS_SLOT  = 8;

    typedef enum logic [1:0] {
        TM_IDLE = 2'd0,
        TM_RUN  = 2'd1,
        TM_HALT = 2'd2
    } tm_state_t;
endpackage

// File: rtl/tsg_slot_timer.sv
module tsg_slot_timer
    import tsg_pkg::*;
#(
    parameter int SLOT_W    = TSG_SLOT_W,
    parameter int BITS_SLOT = TSG_BITS_SLOT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sync,
    output logic              bnd,
    output logic [SLOT_W-1:0] slot_nxt
);
    localparam int CNT_W = $clog2(BITS_SLOT);
    localparam int LIMIT = 1 << (SLOT_W - 1);
    localparam logic [CNT_W-1:0]  LAST  = CNT_W'(BITS_SLOT - 1);
    localparam logic [SLOT_W-1:0] CAP   = SLOT_W'(LIMIT);

    tm_state_t         state, nstate;
    logic [CNT_W-1:0]  bitc;
    logic [SLOT_W-1:0] slot;
    logic              sync_q;
    logic              rise;

    assign rise = sync & ~sync_q;

    always_comb begin
        nstate   = state;
        bnd      = 1'b0;
        slot_nxt = slot;
        unique case (state)
            TM_IDLE, TM_HALT: begin
                if (rise) begin
                    nstate   = TM_RUN;
                    bnd      = 1'b1;
                    slot_nxt = '0;
                end
            end
            TM_RUN: begin
                if (rise) begin
                    bnd      = 1'b1;
                    slot_nxt = '0;
                end else if (bitc == LAST) begin
                    bnd      = 1'b1;
                    slot_nxt = slot + SLOT_W'(1);
                    if (slot_nxt == CAP) nstate = TM_HALT;
                end
            end
            default: nstate = TM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= TM_IDLE;
            sync_q <= 1'b0;
        end else begin
            state  <= nstate;
            sync_q <= sync;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitc <= '0;
            slot <= '0;
        end else begin
            slot <= slot_nxt;
            if (bnd)                  bitc <= '0;
            else if (state == TM_RUN) bitc <= bitc + CNT_W'(1);
        end
    end

    assert_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> (state == TM_RUN && slot == '0 && bitc == '0));

    assert_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TM_RUN && !rise && bitc == LAST && slot < CAP - SLOT_W'(1))
        |=> (slot == $past(slot) + SLOT_W'(1)));

    assert_hold_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == TM_HALT && !rise) |=> (state == TM_HALT && slot == CAP));
endmodule

// File: rtl/tsg_lane.sv
module tsg_lane #(
    parameter int SLOT_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              wr_off,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              bnd,
    input  logic [SLOT_W-1:0] slot_nxt,
    output logic              fs
);
    logic              pend_vld;
    logic [SLOT_W-2:0] pend_slot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_vld  <= 1'b0;
            pend_slot <= '0;
        end else if (wr) begin
            pend_vld  <= ~wr_off & ~wr_slot[SLOT_W-1];
            pend_slot <= wr_slot[SLOT_W-2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   fs <= 1'b0;
        else if (bnd) fs <= pend_vld && (slot_nxt == {1'b0, pend_slot});
    end

    assert_mid_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bnd |=> $stable(fs));

    assert_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bnd && !pend_vld) |=> !fs);
endmodule

// File: rtl/tdm_fsync_gen.sv
module tdm_fsync_gen
    import tsg_pkg::*;
#(
    parameter int LANES     = TSG_LANES,
    parameter int SLOT_W    = TSG_SLOT_W,
    parameter int BITS_SLOT = TSG_BITS_SLOT,
    localparam int IDX_W    = $clog2(2 * LANES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode2,
    input  logic              tx_sync,
    input  logic              rx_sync,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_lane,
    input  logic              cfg_off,
    input  logic [SLOT_W-1:0] cfg_slot,
    output logic [LANES-1:0]  fs_tx,
    output logic [LANES-1:0]  fs_rx,
    output logic              bus_oe,
    output logic              bus_lvl_n
);
    logic              tx_bnd, rx_bnd;
    logic [SLOT_W-1:0] tx_nxt, rx_nxt;
    logic [2*LANES-1:0] fs_all;

    tsg_slot_timer #(.SLOT_W(SLOT_W), .BITS_SLOT(BITS_SLOT)) u_tx_timer (
        .clk(clk), .rst_n(rst_n), .sync(tx_sync),
        .bnd(tx_bnd), .slot_nxt(tx_nxt)
    );

    tsg_slot_timer #(.SLOT_W(SLOT_W), .BITS_SLOT(BITS_SLOT)) u_rx_timer (
        .clk(clk), .rst_n(rst_n), .sync(rx_sync & ~mode2),
        .bnd(rx_bnd), .slot_nxt(rx_nxt)
    );

    for (genvar g = 0; g < 2 * LANES; g++) begin : g_lane
        logic              own_rx;
        logic              l_bnd;
        logic [SLOT_W-1:0] l_nxt;
        assign own_rx = (g >= LANES) && !mode2;
        assign l_bnd  = own_rx ? rx_bnd : tx_bnd;
        assign l_nxt  = own_rx ? rx_nxt : tx_nxt;

        tsg_lane #(.SLOT_W(SLOT_W)) u_lane (
            .clk(clk), .rst_n(rst_n),
            .wr(cfg_we && (cfg_lane == IDX_W'(g))),
            .wr_off(cfg_off), .wr_slot(cfg_slot),
            .bnd(l_bnd), .slot_nxt(l_nxt), .fs(fs_all[g])
        );
    end

    assign fs_tx     = fs_all[LANES-1:0];
    assign fs_rx     = fs_all[2*LANES-1:LANES];
    assign bus_oe    = (|fs_tx) | (mode2 & (|fs_rx));
    assign bus_lvl_n = ~bus_oe;

    assert_bus_tx_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|fs_tx) |-> (bus_oe && !bus_lvl_n));

    assert_bus_m1_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode2 && fs_tx == '0) |-> !bus_oe);
endmodule

// File: tb/tdm_fsync_gen_tb.sv
module tdm_fsync_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode2 = 1'b0;
    logic       tx_sync = 1'b0, rx_sync = 1'b0;
    logic       cfg_we = 1'b0, cfg_off = 1'b0;
    logic [2:0] cfg_lane = '0;
    logic [5:0] cfg_slot = '0;
    logic [3:0] fs_tx, fs_rx;
    logic       bus_oe, bus_lvl_n;

    always #5 clk = ~clk;

    tdm_fsync_gen u_dut (
        .clk(clk), .rst_n(rst_n), .mode2(mode2), .tx_sync(tx_sync), .rx_sync(rx_sync),
        .cfg_we(cfg_we), .cfg_lane(cfg_lane), .cfg_off(cfg_off), .cfg_slot(cfg_slot),
        .fs_tx(fs_tx), .fs_rx(fs_rx), .bus_oe(bus_oe), .bus_lvl_n(bus_lvl_n)
    );

    int    errors = 0, checks = 0;
    string tag = "R1";
    bit    done = 1'b0;

    // behavioural reference: timers 0=tx 1=rx; state 0 idle 1 run 2 halt
    int st [2], bc [2], sl [2], nx [2];
    bit sq [2], bn [2], sy [2];
    bit pv [8];
    int ps [8];
    bit fm [8];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int d = 0; d < 2; d++) begin st[d] = 0; bc[d] = 0; sl[d] = 0; sq[d] = 0; end
            for (int g = 0; g < 8; g++) begin pv[g] = 0; ps[g] = 0; fm[g] = 0; end
        end else begin
            sy[0] = tx_sync;
            sy[1] = rx_sync && !mode2;
            for (int d = 0; d < 2; d++) begin
                bn[d] = 0; nx[d] = sl[d];
                if (sy[d] && !sq[d]) begin
                    st[d] = 1; bc[d] = 0; sl[d] = 0; bn[d] = 1; nx[d] = 0;
                end else if (st[d] == 1) begin
                    if (bc[d] == 7) begin
                        bn[d] = 1; nx[d] = sl[d] + 1; sl[d] = nx[d]; bc[d] = 0;
                        if (nx[d] == 32) st[d] = 2;
                    end else bc[d]++;
                end
                sq[d] = sy[d];
            end
            for (int g = 0; g < 8; g++) begin
                int d;
                d = (g >= 4 && !mode2) ? 1 : 0;
                if (bn[d]) fm[g] = pv[g] && (nx[d] == ps[g]);
            end
            if (cfg_we) begin
                pv[cfg_lane] = !cfg_off && !cfg_slot[5];
                ps[cfg_lane] = int'(cfg_slot[4:0]);
            end
        end
    end

    task automatic chk(bit ok, string t, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", t, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!done) begin
            logic [9:0] e, a;
            logic etx, erx;
            etx = fm[0] | fm[1] | fm[2] | fm[3];
            erx = fm[4] | fm[5] | fm[6] | fm[7];
            e = {fm[3], fm[2], fm[1], fm[0], fm[7], fm[6], fm[5], fm[4],
                 etx | (mode2 & erx), ~(etx | (mode2 & erx))};
            a = {fs_tx, fs_rx, bus_oe, bus_lvl_n};
            chk(a == e, {tag, "/R9 cycle"}, 32'(a), 32'(e));
        end
    end

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    int pc = 0, txper = 0, rxper = 0, rxoff = 0;
    int cnt_tx [4], cnt_rx [4];

    task automatic clr_cnt();
        for (int i = 0; i < 4; i++) begin cnt_tx[i] = 0; cnt_rx[i] = 0; end
    endtask

    task automatic step();
        @(negedge clk);
        for (int i = 0; i < 4; i++) begin cnt_tx[i] += fs_tx[i]; cnt_rx[i] += fs_rx[i]; end
        cfg_we  = 1'b0;
        tx_sync = (txper > 0) && (pc % txper == 0);
        rx_sync = (rxper > 0) && ((pc + rxoff) % rxper == 0);
        pc++;
    endtask

    task automatic run(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic wr(int lane, bit off, logic [5:0] slot);
        step();
        cfg_we = 1'b1; cfg_lane = 3'(lane); cfg_off = off; cfg_slot = slot;
    endtask

    task automatic do_reset(bit m2);
        @(negedge clk);
        rst_n = 1'b0; mode2 = m2; tx_sync = 0; rx_sync = 0; cfg_we = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; pc = 0;
    endtask

    initial begin
        // R1: reset state and silence without assignments
        do_reset(1'b0);
        chk({fs_tx, fs_rx, bus_oe, bus_lvl_n} == 10'b1, "R1 reset", 32'({fs_tx, fs_rx, bus_oe, bus_lvl_n}), 32'h1);
        txper = 64; rxper = 48; rxoff = 5;
        clr_cnt(); run(200);
        chk(cnt_tx[0] + cnt_tx[3] + cnt_rx[0] + cnt_rx[3] == 0, "R1 no-assign", 32'(cnt_tx[0] + cnt_rx[0]), 0);

        // R2 R3 R4 R8 R10: mode 1, full 32-slot frames, offset receive frame
        do_reset(1'b0);
        tag = "R2_R3_R4_R10";
        txper = 256; rxper = 256; rxoff = 37;
        wr(0, 0, 6'd0); wr(1, 0, 6'd1); wr(2, 0, 6'd5); wr(3, 0, 6'd31);
        wr(4, 0, 6'd2); wr(5, 0, 6'd3); wr(6, 1, 6'd4); wr(7, 0, 6'h21);
        run(256 - pc);
        clr_cnt(); run(256);
        chk(cnt_tx[2] == 8, "R3 width tx2", 32'(cnt_tx[2]), 8);
        chk(cnt_tx[1] == 8, "R10 tx1", 32'(cnt_tx[1]), 8);
        chk(cnt_rx[0] == 8, "R4 rx0", 32'(cnt_rx[0]), 8);
        chk(cnt_rx[2] == 0, "R8 off", 32'(cnt_rx[2]), 0);
        chk(cnt_rx[3] == 0, "R8 bit5", 32'(cnt_rx[3]), 0);

        // R7: rewrites at arbitrary points inside slots
        tag = "R7";
        run(13); wr(1, 0, 6'd2);
        run(29); wr(2, 0, 6'd0);
        run(3);  wr(4, 0, 6'd9);
        run(300);
        chk(1'b1, "R7 mid-slot run", 0, 0);

        // R6: short frames never reach slot 31; then frame starts stop
        do_reset(1'b0);
        tag = "R6";
        txper = 80; rxper = 0;
        wr(0, 0, 6'd0); wr(3, 0, 6'd31); wr(2, 0, 6'd9);
        clr_cnt(); run(400);
        chk(cnt_tx[3] == 0, "R6 beyond frame", 32'(cnt_tx[3]), 0);
        chk(cnt_tx[2] == 40, "R6 last slot", 32'(cnt_tx[2]), 40);
        txper = 0;
        run(300);
        clr_cnt(); run(200);
        chk(cnt_tx[0] + cnt_tx[2] == 0, "R6 halted", 32'(cnt_tx[0] + cnt_tx[2]), 0);
        txper = 256; pc = 0;
        clr_cnt(); run(256);
        chk(cnt_tx[0] == 8, "R6 resume", 32'(cnt_tx[0]), 8);

        // R5: shared mode, receive frame-start toggled but ignored
        do_reset(1'b1);
        tag = "R5";
        txper = 256; rxper = 37; rxoff = 0;
        wr(4, 0, 6'd1); wr(5, 0, 6'd7); wr(0, 0, 6'd3);
        run(256 - pc);
        clr_cnt(); run(256);
        chk(cnt_rx[0] == 8, "R5 rx0 on tx timing", 32'(cnt_rx[0]), 8);
        chk(cnt_rx[1] == 8, "R5 rx1", 32'(cnt_rx[1]), 8);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule